// File: doc/BRIEF.md
# Dual-Window Banked Address Mapper

This block turns host accesses that fall inside a 64 KB legacy graphics aperture into physical video-memory addresses. The aperture has two 32 KB halves, and each half takes its bank from its own page register. Software stores a bank number in each page register. The mapper multiplies that bank number by the current bank unit and adds the in-window offset. The result is a 21-bit address, and a valid flag comes out in the same cycle.

A control bit sets what the upper half's offset is measured from. When the bit is set, the offset is taken from the upper half's own base, so loading page 1 with page 0 plus 8 gives one seamless 64 KB window. When the bit is clear, the upper half keeps the full aperture offset, and software loads both page registers with the same value.

The bank unit has three sizes with a fixed priority. A planar-mode input selects 1 KB. If that input is low, a control bit selects 16 KB. With neither, the unit is 4 KB. The control and page registers sit behind a key register and take writes only while it holds the unlock code.

Top module: `bank_window_mapper`

## Requirements
- R1: While locked, writes to the control register (index 1) and to the page registers (indices 2 and 3) leave them unchanged.
- R2: The key register (index 0) is always writable. Writing it with low nibble 4'h5 unlocks the block. Writing it with any other low nibble locks the block.
- R3: Host offsets 16'h0000 to 16'h7FFF take page register 0 (index 2). Offsets 16'h8000 to 16'hFFFF take page register 1 (index 3).
- R4: With control bit 1 clear and planar_mode low, the bank unit is 4 KB, so map_addr = page * 4096 + effective offset.
- R5: With control bit 1 set and planar_mode low, the bank unit is 16 KB, so map_addr = page * 16384 + effective offset.
- R6: With planar_mode high, the bank unit is 1 KB whatever the value of control bit 1.
- R7: With control bit 0 set, an upper-half access uses host_off - 16'h8000 as its effective offset. Page 1 = page 0 + 8 then gives a contiguous 64 KB window.
- R8: With control bit 0 clear, an upper-half access uses the full host_off as its effective offset.
- R9: map_addr is the sum kept to 21 bits. Any carry above bit 20 is dropped.
- R10: After reset the block is locked, both page registers are zero and both control bits are clear, so map_addr equals host_off.
- R11: While unlocked, a read returns the stored value: the key at index 0, the control register at index 1 with bit 0 for the half-relative offset, bit 1 for the 16 KB unit and the other bits zero, and the pages at indices 2 and 3. While locked, every read returns zero.
- R12: map_valid follows host_req in the same cycle. map_addr is zero while host_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| planar_mode | input | 1 | Selects the 1 KB bank unit |
| host_req | input | 1 | Host access in the aperture |
| host_off | input | 16 | Offset inside the 64 KB aperture |
| map_addr | output | 21 | Translated video-memory address |
| map_valid | output | 1 | Translation valid |

## Verification
The hardest state to reach from the ports is a locked write to a register that already holds a non-reset value. Seeing that such a write was ignored needs a write while unlocked, then a lock, then the rejected write, then an unlock so the value can be read back. The bench runs that whole sequence. It also drives bank values large enough that the 16 KB base overflows 21 bits, and a page pair offset by 8 so the two halves of the window meet, which exercises carry truncation and the seamless window.

// File: rtl/bwm_pkg.sv
package bwm_pkg;
  typedef struct packed {
    logic gran16;     // bit 1: 16 KB bank unit
    logic split_rel;  // bit 0: upper half relative to its own base
  } bwm_ctrl_t;

  localparam int unsigned IDX_KEY  = 0;
  localparam int unsigned IDX_CTRL = 1;
  localparam int unsigned IDX_PAGE = 2;
endpackage

// File: rtl/bwm_rst_sync.sv
module bwm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/bwm_regs.sv
module bwm_regs
  import bwm_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned PAGE_W    = 8,
  parameter int unsigned NUM_PAGES = 2,
  parameter int unsigned REG_AW    = 2,
  parameter logic [3:0]  KEY_CODE  = 4'h5
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic                            rd_en,
  input  logic [REG_AW-1:0]               addr,
  input  logic [DATA_W-1:0]               wdata,
  output logic [DATA_W-1:0]               rdata,
  output logic                            unlocked,
  output bwm_ctrl_t                       ctrl,
  output logic [NUM_PAGES-1:0][PAGE_W-1:0] pages
);
  localparam int unsigned CTRL_W = $bits(bwm_ctrl_t);

  logic [DATA_W-1:0] key_q, key_d;
  bwm_ctrl_t         ctrl_q, ctrl_d;
  logic              key_we, ctrl_we;

  assign unlocked = (key_q[3:0] == KEY_CODE);
  assign key_we   = wr_en && (addr == REG_AW'(IDX_KEY));
  assign ctrl_we  = wr_en && unlocked && (addr == REG_AW'(IDX_CTRL));

  always_comb begin
    key_d  = key_q;
    ctrl_d = ctrl_q;
    if (key_we)  key_d  = wdata;
    if (ctrl_we) ctrl_d = bwm_ctrl_t'(wdata[CTRL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q  <= '0;
      ctrl_q <= '0;
    end else begin
      key_q  <= key_d;
      ctrl_q <= ctrl_d;
    end
  end

  for (genvar i = 0; i < NUM_PAGES; i++) begin : g_page
    logic              we;
    logic [PAGE_W-1:0] pg_q, pg_d;

    assign we = wr_en && unlocked && (addr == REG_AW'(IDX_PAGE + i));

    always_comb begin
      pg_d = pg_q;
      if (we) pg_d = PAGE_W'(wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pg_q <= '0;
      else        pg_q <= pg_d;
    end

    assign pages[i] = pg_q;
  end

  assign ctrl = ctrl_q;

  always_comb begin
    rdata = '0;
    if (rd_en && unlocked) begin
      if (addr == REG_AW'(IDX_KEY))  rdata = key_q;
      if (addr == REG_AW'(IDX_CTRL)) rdata = DATA_W'(ctrl_q);
      for (int i = 0; i < NUM_PAGES; i++)
        if (addr == REG_AW'(IDX_PAGE + i)) rdata = DATA_W'(pages[i]);
    end
  end

  // R1: a locked write to a guarded register changes nothing
  a_r1_locked_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !unlocked && addr != REG_AW'(IDX_KEY)) |=> ($stable(ctrl_q) && $stable(pages)));

  // R2: writing the key code unlocks on the next cycle
  a_r2_key_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == REG_AW'(IDX_KEY) && wdata[3:0] == KEY_CODE) |=> unlocked);

  // R2: any other key value locks
  a_r2_key_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == REG_AW'(IDX_KEY) && wdata[3:0] != KEY_CODE) |=> !unlocked);
endmodule

// File: rtl/bwm_xlate.sv
module bwm_xlate
  import bwm_pkg::*;
#(
  parameter int unsigned ADDR_W    = 21,
  parameter int unsigned OFF_W     = 16,
  parameter int unsigned PAGE_W    = 8,
  parameter int unsigned NUM_PAGES = 2,
  parameter int unsigned SH_SMALL  = 10,
  parameter int unsigned SH_NORM   = 12,
  parameter int unsigned SH_LARGE  = 14
) (
  input  logic                             host_req,
  input  logic [OFF_W-1:0]                 host_off,
  input  logic                             planar_mode,
  input  bwm_ctrl_t                        ctrl,
  input  logic [NUM_PAGES-1:0][PAGE_W-1:0] pages,
  output logic [ADDR_W-1:0]                map_addr,
  output logic                             map_valid
);
  localparam int unsigned HALF_W = OFF_W - 1;

  logic              upper;
  logic [PAGE_W-1:0] page_sel;
  logic [OFF_W-1:0]  eff_off;
  logic [ADDR_W-1:0] page_ext;
  logic [ADDR_W-1:0] base;

  assign upper    = host_off[OFF_W-1];
  assign page_sel = pages[upper];
  assign page_ext = ADDR_W'(page_sel);

  always_comb begin
    if (upper && ctrl.split_rel) eff_off = {1'b0, host_off[HALF_W-1:0]};
    else                         eff_off = host_off;
  end

  always_comb begin
    if (planar_mode)      base = page_ext << SH_SMALL;
    else if (ctrl.gran16) base = page_ext << SH_LARGE;
    else                  base = page_ext << SH_NORM;
  end

  assign map_valid = host_req;
  assign map_addr  = host_req ? (base + ADDR_W'(eff_off)) : '0;
endmodule

// File: rtl/bank_window_mapper.sv
module bank_window_mapper
  import bwm_pkg::*;
#(
  parameter int unsigned ADDR_W = 21,
  parameter int unsigned OFF_W  = 16,
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned REG_AW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              planar_mode,
  input  logic              host_req,
  input  logic [OFF_W-1:0]  host_off,
  output logic [ADDR_W-1:0] map_addr,
  output logic              map_valid
);
  localparam int unsigned NUM_PAGES = 2;
  localparam int unsigned SH_NORM   = 12;
  localparam int unsigned LOW_KEEP  = 10;
  localparam int unsigned PAIR_STEP = (1 << (OFF_W - 1)) >> SH_NORM;

  logic                             rst_sync_n;
  logic                             unlocked;
  bwm_ctrl_t                        ctrl;
  logic [NUM_PAGES-1:0][PAGE_W-1:0] pages;

  bwm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bwm_regs #(
    .DATA_W(DATA_W), .PAGE_W(PAGE_W), .NUM_PAGES(NUM_PAGES), .REG_AW(REG_AW)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (reg_wr),
    .rd_en    (reg_rd),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .unlocked (unlocked),
    .ctrl     (ctrl),
    .pages    (pages)
  );

  bwm_xlate #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .PAGE_W(PAGE_W), .NUM_PAGES(NUM_PAGES),
    .SH_NORM(SH_NORM)
  ) u_xlate (
    .host_req    (host_req),
    .host_off    (host_off),
    .planar_mode (planar_mode),
    .ctrl        (ctrl),
    .pages       (pages),
    .map_addr    (map_addr),
    .map_valid   (map_valid)
  );

  // R11: a locked read returns zero
  a_r11_locked_read_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_rd && !unlocked) |-> (reg_rdata == '0));

  // R12: no access gives no address
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !host_req |-> (map_addr == '0 && !map_valid));

  // R4 R5 R6: every unit is at least 1 KB, so the low offset bits pass through
  a_r4_low_bits_pass: assert property (@(posedge clk) disable iff (!rst_sync_n)
    host_req |-> (map_addr[LOW_KEEP-1:0] == host_off[LOW_KEEP-1:0]));

  // R7: page 1 = page 0 + 8 with half-relative offsets gives one flat window
  a_r7_seamless_window: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (host_req && ctrl.split_rel && !ctrl.gran16 && !planar_mode &&
     {1'b0, pages[1]} == {1'b0, pages[0]} + (PAGE_W+1)'(PAIR_STEP))
    |-> (map_addr == ADDR_W'((ADDR_W'(pages[0]) << SH_NORM) + ADDR_W'(host_off))));
endmodule

// File: tb/bank_window_mapper_tb.sv
module bank_window_mapper_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd, planar_mode, host_req;
  logic [1:0]  reg_addr;
  logic [7:0]  reg_wdata, reg_rdata;
  logic [15:0] host_off;
  logic [20:0] map_addr;
  logic        map_valid;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  bank_window_mapper u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .planar_mode(planar_mode), .host_req(host_req), .host_off(host_off),
    .map_addr(map_addr), .map_valid(map_valid)
  );

  typedef struct packed {
    logic        split;
    logic        g16;
    logic        pl;
    logic [7:0]  p0;
    logic [7:0]  p1;
    logic [15:0] off;
    logic [20:0] exp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b0, 8'h03, 8'h05, 16'h1234, 21'h004234},
    '{1'b0, 1'b0, 1'b0, 8'h03, 8'h05, 16'h9234, 21'h00E234},
    '{1'b1, 1'b0, 1'b0, 8'h03, 8'h05, 16'h9234, 21'h006234},
    '{1'b1, 1'b0, 1'b0, 8'h10, 8'h18, 16'h8000, 21'h018000},
    '{1'b0, 1'b1, 1'b0, 8'h02, 8'h07, 16'h0100, 21'h008100},
    '{1'b0, 1'b1, 1'b1, 8'h02, 8'h07, 16'h0100, 21'h000900},
    '{1'b0, 1'b0, 1'b1, 8'h40, 8'h41, 16'hC000, 21'h01C400},
    '{1'b0, 1'b1, 1'b0, 8'hFF, 8'hFF, 16'hFFFF, 21'h00BFFF},
    '{1'b1, 1'b1, 1'b0, 8'h80, 8'h80, 16'h8001, 21'h000001},
    '{1'b0, 1'b0, 1'b0, 8'hFF, 8'h00, 16'h7FFF, 21'h106FFF},
    '{1'b0, 1'b0, 1'b0, 8'hFF, 8'h00, 16'h8000, 21'h008000}
  };
  localparam string TAGS [NV] = '{
    "R4", "R8", "R7", "R7", "R5", "R6", "R6", "R9", "R9", "R3", "R3"
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic access(input logic [15:0] o);
    @(negedge clk);
    host_req = 1'b1; host_off = o;
    #1;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    planar_mode = 1'b0; host_req = 1'b0; host_off = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: reset state, bank 0 maps straight through
    access(16'h9ABC);
    chk("R10 addr after reset", 32'(map_addr), 32'h09ABC);
    chk("R12 valid follows req", 32'(map_valid), 32'h1);
    host_req = 1'b0;
    #1 chk("R12 idle addr zero", 32'(map_addr), 32'h0);
    chk("R12 idle valid low", 32'(map_valid), 32'h0);
    rd(2'd2, d);
    chk("R11 locked read zero", 32'(d), 32'h0);

    // Table-driven walk
    wr(2'd0, 8'h05);
    for (int i = 0; i < NV; i++) begin
      wr(2'd1, {6'b0, VECS[i].g16, VECS[i].split});
      wr(2'd2, VECS[i].p0);
      wr(2'd3, VECS[i].p1);
      planar_mode = VECS[i].pl;
      access(VECS[i].off);
      chk(TAGS[i], 32'(map_addr), 32'(VECS[i].exp));
      host_req = 1'b0;
    end
    planar_mode = 1'b0;

    // R11: readback while unlocked
    wr(2'd0, 8'hA5);
    rd(2'd0, d);
    chk("R11 key readback", 32'(d), 32'hA5);
    wr(2'd1, 8'hFF);
    rd(2'd1, d);
    chk("R11 ctrl reserved bits zero", 32'(d), 32'h03);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h33);
    wr(2'd3, 8'h44);
    rd(2'd3, d);
    chk("R11 page1 readback", 32'(d), 32'h44);

    // R2 and R1: lock, attempt writes, unlock and read back
    wr(2'd0, 8'h06);
    rd(2'd2, d);
    chk("R11 read zero after lock", 32'(d), 32'h0);
    wr(2'd2, 8'h99);
    wr(2'd1, 8'h03);
    access(16'h0010);
    chk("R1 locked write has no effect on map", 32'(map_addr), 32'h33010);
    host_req = 1'b0;
    wr(2'd0, 8'h15);
    rd(2'd2, d);
    chk("R1 page0 unchanged", 32'(d), 32'h33);
    rd(2'd1, d);
    chk("R1 ctrl unchanged", 32'(d), 32'h00);
    chk("R2 low nibble 5 unlocks", 32'(d === 8'h00 && reg_rdata === 8'h00), 32'h1);
    rd(2'd0, d);
    chk("R2 key 0x15 unlocked", 32'(d), 32'h15);

    // R10: reset again restores defaults
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    wr(2'd0, 8'h05);
    rd(2'd2, d);
    chk("R10 page0 zero after reset", 32'(d), 32'h0);
    rd(2'd1, d);
    chk("R10 ctrl zero after reset", 32'(d), 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule